// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds two pending sets with one bit per processor, one for inter-processor interrupts and one for interval-timer interrupts. Each pending bit drives its own interrupt output. Software reaches the block through a small register port with four selects: a shared miscellaneous register and three direct-access registers.

A write to the miscellaneous register can request inter-processor interrupts, clear them, and clear timer interrupts, all in one access, through separate 4-bit processor masks. A periodic tick input marks the timer interrupt pending on every configured processor. The block reports misuse on two registered one-cycle flags. A warning flags a redundant request, or a clear with nothing pending. An error flags a write that carries nothing the block can act on.

Reads are combinational from the select and the requesting processor's ID. The port has no handshake: a write takes effect at the clock edge on which `wr_en_i` is high.

Top module: `ipi_tmr_intc`

## Requirements
- R1: After reset, both pending sets are zero, so every interrupt output is low, and `warn_o` and `err_o` are low.
- R2: A write to select 0 (miscellaneous) sets the inter-processor pending bit of each processor whose bit is set in write data bits 15:12. The output follows on the next cycle.
- R3: In the same kind of write, bits 11:8 clear inter-processor pending bits and bits 7:4 clear timer pending bits, and all fields act in one write. When one write both requests and clears the same processor, the request is applied first and the clear wins.
- R4: Requesting an inter-processor interrupt for a processor that already has one pending leaves the set unchanged and pulses `warn_o`.
- R5: Clearing an inter-processor interrupt for a processor that has none pending, and that the same write does not request, leaves the set unchanged and pulses `warn_o`.
- R6: A timer clear removes only bits that are both selected and pending. Selecting a processor with no timer interrupt pending changes nothing and raises no warning.
- R7: A high `tick_i` sets the timer pending bit of every configured processor. When a tick and a timer clear happen in the same cycle, the tick wins.
- R8: A miscellaneous write whose bits 15:4 are all zero and whose bit 28 is zero pulses `err_o` and changes nothing. Bit 28 alone is an accepted error acknowledge: it changes nothing and raises no flag.
- R9: A read of select 0 returns the requesting processor's ID in bits 1:0, the timer set in bits 7:4 and the inter-processor set in bits 11:8. All other bits read zero.
- R10: Select 1 reads the inter-processor set in bits 3:0, and a write to it clears by the mask in bits 3:0. Select 2 does the same for the timer set. Select 3 requests inter-processor interrupts by the mask in bits 3:0 and reads zero. On selects 1 to 3, a write with a zero mask pulses `err_o`.
- R11: `warn_o` and `err_o` are high only for the single cycle after the write that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Periodic timer tick, one cycle per period |
| wr_en_i | input | 1 | Write strobe for the selected register |
| sel_i | input | 2 | Register select: 0 misc, 1 IPI set, 2 timer set, 3 IPI request |
| wdata_i | input | DATA_W | Write data |
| cpu_id_i | input | 2 | ID of the processor making the access |
| rdata_o | output | DATA_W | Read data for the selected register |
| ipi_irq_o | output | NUM_CPU | Inter-processor interrupt per processor |
| tmr_irq_o | output | NUM_CPU | Timer interrupt per processor |
| warn_o | output | 1 | Redundant request or empty clear, one cycle |
| err_o | output | 1 | Unsupported or empty-mask write, one cycle |

## Verification
The bound assertions check on every cycle that miscellaneous-write requests land and clears take effect, and that a tick fills the timer set. They also check that the sets hold when no write or tick occurs, that flags only follow writes, that an error write leaves the inter-processor set alone, and that the miscellaneous read carries the ID and zero padding. Only the bench scenarios can show the rules that depend on the prior state: which redundant accesses warn and which do not, request-then-clear ordering within one write, tick priority over a clear, and the exact read-back values of the direct registers.

// File: rtl/ipi_tmr_pkg.sv
package ipi_tmr_pkg;
  localparam int FIELD_W    = 4;
  localparam int REQ_LSB    = 12;
  localparam int IPICLR_LSB = 8;
  localparam int TMRCLR_LSB = 4;
  localparam int ACK_BIT    = 28;
  localparam int ID_W       = 2;

  typedef enum logic [1:0] {
    SEL_MISC   = 2'd0,
    SEL_IPI    = 2'd1,
    SEL_TMR    = 2'd2,
    SEL_IPIREQ = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [FIELD_W-1:0] ipi_set;
    logic [FIELD_W-1:0] ipi_clr;
    logic [FIELD_W-1:0] tmr_clr;
    logic               bad;
  } wr_cmd_t;
endpackage

// File: rtl/ipi_tmr_wdec.sv
module ipi_tmr_wdec
  import ipi_tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wr_en_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output wr_cmd_t           cmd_o
);
  logic [FIELD_W-1:0] low_mask;
  assign low_mask = wdata_i[FIELD_W-1:0];

  always_comb begin
    cmd_o = '0;
    if (wr_en_i) begin
      unique case (reg_sel_e'(sel_i))
        SEL_MISC: begin
          cmd_o.ipi_set = wdata_i[REQ_LSB    +: FIELD_W];
          cmd_o.ipi_clr = wdata_i[IPICLR_LSB +: FIELD_W];
          cmd_o.tmr_clr = wdata_i[TMRCLR_LSB +: FIELD_W];
          cmd_o.bad     = (wdata_i[REQ_LSB+FIELD_W-1:TMRCLR_LSB] == '0)
                          && !wdata_i[ACK_BIT];
        end
        SEL_IPI: begin
          cmd_o.ipi_clr = low_mask;
          cmd_o.bad     = (low_mask == '0);
        end
        SEL_TMR: begin
          cmd_o.tmr_clr = low_mask;
          cmd_o.bad     = (low_mask == '0);
        end
        SEL_IPIREQ: begin
          cmd_o.ipi_set = low_mask;
          cmd_o.bad     = (low_mask == '0);
        end
        default: cmd_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ipi_tmr_pend.sv
module ipi_tmr_pend #(
  parameter int N        = 4,
  parameter bit SET_WINS = 1'b0,
  parameter bit WARN_EN  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic         warn_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic [N-1:0] bit_warn;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (SET_WINS) begin : g_set_first
      assign pend_d[i] = set_i[i] | (pend_q[i] & ~clr_i[i]);
    end else begin : g_clr_last
      assign pend_d[i] = (pend_q[i] | set_i[i]) & ~clr_i[i];
    end
    if (WARN_EN) begin : g_warn
      assign bit_warn[i] = (set_i[i] & pend_q[i])
                         | (clr_i[i] & ~pend_q[i] & ~set_i[i]);
    end else begin : g_nowarn
      assign bit_warn[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign warn_o = |bit_warn;
endmodule

// File: rtl/ipi_tmr_rmux.sv
module ipi_tmr_rmux
  import ipi_tmr_pkg::*;
#(
  parameter int N      = 4,
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel_i,
  input  logic [ID_W-1:0]   cpu_id_i,
  input  logic [N-1:0]      ipi_i,
  input  logic [N-1:0]      tmr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [FIELD_W-1:0] ipi_f;
  logic [FIELD_W-1:0] tmr_f;
  assign ipi_f = FIELD_W'(ipi_i);
  assign tmr_f = FIELD_W'(tmr_i);

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(sel_i))
      SEL_MISC: begin
        rdata_o[ID_W-1:0]                = cpu_id_i;
        rdata_o[TMRCLR_LSB +: FIELD_W]   = tmr_f;
        rdata_o[IPICLR_LSB +: FIELD_W]   = ipi_f;
      end
      SEL_IPI:    rdata_o[FIELD_W-1:0] = ipi_f;
      SEL_TMR:    rdata_o[FIELD_W-1:0] = tmr_f;
      SEL_IPIREQ: rdata_o = '0;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ipi_tmr_intc.sv
module ipi_tmr_intc
  import ipi_tmr_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [1:0]         sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [1:0]         cpu_id_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_CPU-1:0] ipi_irq_o,
  output logic [NUM_CPU-1:0] tmr_irq_o,
  output logic               warn_o,
  output logic               err_o
);
  localparam logic [NUM_CPU-1:0] ALL_CPU = '1;

  wr_cmd_t      cmd;
  logic         ipi_warn;
  logic         tmr_warn;
  logic         warn_q;
  logic         err_q;
  logic [NUM_CPU-1:0] tick_set;

  ipi_tmr_wdec #(.DATA_W(DATA_W)) u_wdec (
    .wr_en_i (wr_en_i),
    .sel_i   (sel_i),
    .wdata_i (wdata_i),
    .cmd_o   (cmd)
  );

  ipi_tmr_pend #(.N(NUM_CPU), .SET_WINS(1'b0), .WARN_EN(1'b1)) u_ipi (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (cmd.ipi_set[NUM_CPU-1:0]),
    .clr_i  (cmd.ipi_clr[NUM_CPU-1:0]),
    .pend_o (ipi_irq_o),
    .warn_o (ipi_warn)
  );

  assign tick_set = tick_i ? ALL_CPU : '0;

  ipi_tmr_pend #(.N(NUM_CPU), .SET_WINS(1'b1), .WARN_EN(1'b0)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (tick_set),
    .clr_i  (cmd.tmr_clr[NUM_CPU-1:0]),
    .pend_o (tmr_irq_o),
    .warn_o (tmr_warn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      warn_q <= ipi_warn | tmr_warn;
      err_q  <= cmd.bad;
    end
  end

  assign warn_o = warn_q;
  assign err_o  = err_q;

  ipi_tmr_rmux #(.N(NUM_CPU), .DATA_W(DATA_W)) u_rmux (
    .sel_i    (sel_i),
    .cpu_id_i (cpu_id_i),
    .ipi_i    (ipi_irq_o),
    .tmr_i    (tmr_irq_o),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/ipi_tmr_intc_chk.sv
module ipi_tmr_intc_chk #(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_i,
  input logic               wr_en_i,
  input logic [1:0]         sel_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [1:0]         cpu_id_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_CPU-1:0] ipi_irq_o,
  input logic [NUM_CPU-1:0] tmr_irq_o,
  input logic               warn_o,
  input logic               err_o
);
  logic               misc_wr;
  logic [NUM_CPU-1:0] req_n;
  logic [NUM_CPU-1:0] clr_n;
  logic [NUM_CPU-1:0] net_set;
  assign misc_wr = wr_en_i && (sel_i == 2'd0);
  assign req_n   = NUM_CPU'(wdata_i[15:12]);
  assign clr_n   = NUM_CPU'(wdata_i[11:8]);
  assign net_set = req_n & ~clr_n;

  p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr |=> ((ipi_irq_o & $past(net_set)) == $past(net_set)));

  p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr |=> ((ipi_irq_o & $past(clr_n)) == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !tick_i) |=> ($stable(ipi_irq_o) && $stable(tmr_irq_o)));

  p_tick_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (tmr_irq_o == '1));

  p_err_nochg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(wr_en_i) && $stable(ipi_irq_o)));

  p_misc_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 2'd0) |-> (rdata_o[1:0] == cpu_id_i && rdata_o[3:2] == 2'b00
                         && rdata_o[DATA_W-1:12] == '0));

  p_warn_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    warn_o |-> $past(wr_en_i));
endmodule

bind ipi_tmr_intc ipi_tmr_intc_chk #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .sel_i     (sel_i),
  .wdata_i   (wdata_i),
  .cpu_id_i  (cpu_id_i),
  .rdata_o   (rdata_o),
  .ipi_irq_o (ipi_irq_o),
  .tmr_irq_o (tmr_irq_o),
  .warn_o    (warn_o),
  .err_o     (err_o)
);

// File: tb/ipi_tmr_intc_tb_top.sv
`timescale 1ns/1ps
module ipi_tmr_intc_tb_top;
  localparam int N  = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    sel_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [1:0]    cpu_id_i = '0;
  logic [DW-1:0] rdata_o;
  logic [N-1:0]  ipi_irq_o;
  logic [N-1:0]  tmr_irq_o;
  logic          warn_o;
  logic          err_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ipi_tmr_intc #(.NUM_CPU(N), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .sel_i(sel_i), .wdata_i(wdata_i), .cpu_id_i(cpu_id_i),
    .rdata_o(rdata_o), .ipi_irq_o(ipi_irq_o), .tmr_irq_o(tmr_irq_o),
    .warn_o(warn_o), .err_o(err_o)
  );

  typedef struct packed {
    logic        tick;
    logic        wr;
    logic [1:0]  sel;
    logic [31:0] wdata;
    logic [3:0]  ipi;
    logic [3:0]  tmr;
    logic        warn;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 2'd0, 32'h0000_3000, 4'h3, 4'h0, 1'b0, 1'b0, 8'd2},  // R2 request 0011
    '{1'b0, 1'b1, 2'd0, 32'h0000_1000, 4'h3, 4'h0, 1'b1, 1'b0, 8'd4},  // R4 duplicate
    '{1'b1, 1'b0, 2'd0, 32'h0000_0000, 4'h3, 4'hF, 1'b0, 1'b0, 8'd7},  // R7 tick
    '{1'b0, 1'b1, 2'd0, 32'h0000_0130, 4'h2, 4'hC, 1'b0, 1'b0, 8'd3},  // R3 combined clears
    '{1'b0, 1'b1, 2'd0, 32'h0000_0400, 4'h2, 4'hC, 1'b1, 1'b0, 8'd5},  // R5 empty clear
    '{1'b0, 1'b1, 2'd0, 32'h0000_0030, 4'h2, 4'hC, 1'b0, 1'b0, 8'd6},  // R6 timer clear of idle
    '{1'b0, 1'b1, 2'd0, 32'h0000_0000, 4'h2, 4'hC, 1'b0, 1'b1, 8'd8},  // R8 unsupported
    '{1'b0, 1'b1, 2'd0, 32'h1000_0000, 4'h2, 4'hC, 1'b0, 1'b0, 8'd8},  // R8 ack only
    '{1'b0, 1'b1, 2'd3, 32'h0000_0009, 4'hB, 4'hC, 1'b0, 1'b0, 8'd10}, // R10 request reg
    '{1'b0, 1'b1, 2'd1, 32'h0000_0008, 4'h3, 4'hC, 1'b0, 1'b0, 8'd10}, // R10 IPI clear reg
    '{1'b0, 1'b1, 2'd2, 32'h0000_0004, 4'h3, 4'h8, 1'b0, 1'b0, 8'd10}, // R10 timer clear reg
    '{1'b0, 1'b1, 2'd3, 32'h0000_0000, 4'h3, 4'h8, 1'b0, 1'b1, 8'd10}, // R10 zero mask
    '{1'b1, 1'b1, 2'd2, 32'h0000_000F, 4'h3, 4'hF, 1'b0, 1'b0, 8'd7},  // R7 tick beats clear
    '{1'b0, 1'b1, 2'd0, 32'h0000_4400, 4'h3, 4'hF, 1'b0, 1'b0, 8'd3},  // R3 request then clear
    '{1'b0, 1'b0, 2'd0, 32'h0000_0000, 4'h3, 4'hF, 1'b0, 1'b0, 8'd11}  // R11 flags drop
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag, input logic [3:0] ipi, input logic [3:0] tmr,
                            input logic w, input logic e);
    check(tag, {22'd0, ipi_irq_o, tmr_irq_o, warn_o, err_o}, {22'd0, ipi, tmr, w, e});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1 reset state", 4'h0, 4'h0, 1'b0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      tick_i  = VEC[k].tick;
      wr_en_i = VEC[k].wr;
      sel_i   = VEC[k].sel;
      wdata_i = VEC[k].wdata;
      @(negedge clk);
      tick_i  = 1'b0;
      wr_en_i = 1'b0;
      check_outs($sformatf("R%0d vector %0d", VEC[k].req, k),
                 VEC[k].ipi, VEC[k].tmr, VEC[k].warn, VEC[k].err);
    end

    // R9 miscellaneous read layout: ipi=0011 tmr=1111 id=2
    sel_i = 2'd0; cpu_id_i = 2'd2; wdata_i = '0;
    #1 check("R9 misc read id2", rdata_o, 32'h0000_03F2);
    cpu_id_i = 2'd1;
    #1 check("R9 misc read id1", rdata_o, 32'h0000_03F1);
    // R10 direct reads
    sel_i = 2'd1;
    #1 check("R10 ipi set read", rdata_o, 32'h0000_0003);
    sel_i = 2'd2;
    #1 check("R10 timer set read", rdata_o, 32'h0000_000F);
    sel_i = 2'd3;
    #1 check("R10 request reg reads zero", rdata_o, 32'h0);

    // R1 reset from a busy state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_outs("R1 reset clears state", 4'h0, 4'h0, 1'b0, 1'b0);
    sel_i = 2'd0; cpu_id_i = 2'd0;
    #1 check("R1 R9 misc read after reset", rdata_o, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule